// File: doc/BRIEF.md
# Sector page-load program controller

This block is a cycle-based model of the write path of a nonvolatile memory that is programmed one 256-byte sector at a time. The three active-low strobes (chip select, write, output enable) are sampled on the system clock. Chip select and write are merged into one internal write strobe, which is active only while output enable is high. Each write strobe adds one byte to a page buffer. The byte offset is the low eight address bits, and the upper address bits name the sector. The sector is fixed by the first byte of a load window. Bytes may arrive in any order.

The load window closes when the strobe has stayed quiet for a programmable number of cycles. A timed cycle then starts. It first erases the target sector to all-ones and then writes every buffered byte into a register-modelled array. Offsets that were never loaded stay erased. While the cycle runs, any read returns a status byte. That byte carries the inverse of the top bit of the last accepted byte, so software can poll for completion. Outside the cycle, reads return the stored data.

Top module: `pageprog_top`

## Requirements
- R1: `dataOe` is high only while `ceN` and `oeN` are low and `weN` is high. At that time `dataOut` shows the stored byte at `addr`, or the status byte during a program cycle. Otherwise `dataOe` is low and `dataOut` is 0.
- R2: The write strobe is active while `ceN` and `weN` are both low and `oeN` is high. The address is sampled on the first clock where the strobe is active, that is, after the later of the two falling edges. The data is sampled on the first clock where it is inactive again, that is, after the earlier rising edge. An attempt made with `oeN` low loads nothing.
- R3: Loaded bytes may target any offset in any order. When an offset is loaded twice in a window, the later value is programmed.
- R4: The sector (address bits above bit 7) is taken from the first load of a window. A load that names another sector is discarded: it stores no data and does not change the status bit.
- R5: With no new strobe, `busy` rises exactly LOAD_TIMEOUT clock cycles after the clock that captured the last byte. A strobe that starts earlier keeps the window open.
- R6: After a program cycle, every offset of the sector that was not loaded reads FFh. Loaded offsets read the programmed value, and other sectors keep their contents. After reset, the whole array reads FFh.
- R7: `busy` stays high for exactly PROG_CYCLES clock cycles. The erase phase is the first of them, and the remaining cycles form the program phase.
- R8: During a program cycle, a read returns bit 7 equal to the inverse of bit 7 of the last accepted byte, with bits 6:0 equal to 0.
- R9: Write strobes that start while `busy` is high are ignored. They change neither the programmed data nor the status bit.
- R10: The per-byte valid mask is cleared when a new window opens. Bytes loaded in an earlier window are not programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| addr | input | 8+SECTOR_BITS | Sector number in upper bits, byte offset in low 8 bits |
| dataIn | input | 8 | Byte to load |
| dataOut | output | 8 | Read data or status byte, 0 when not driven |
| dataOe | output | 1 | High while the block drives `dataOut` |
| busy | output | 1 | High during the erase-and-program cycle |

## Verification
On every cycle, the assertions check the following:
- `busy` only rises out of an open window.
- The erase phase is followed directly by the program phase, and that phase runs without interruption.
- The valid mask is empty right after a window opens.
- Foreign-sector loads leave the mask and status bit untouched.
- The status bit holds still while busy.
- The status byte is what a read sees during the cycle.

Only the bench scenarios can show the end-to-end results: the exact timeout and busy length, the strobe-edge sampling order, the last-write-wins order, and the FFh fill of unloaded offsets after the cycle completes.

// File: rtl/pageprog_pkg.sv
package pageprog_pkg;
  localparam int BYTE_W     = 8;
  localparam int OFFS_W     = 8;
  localparam int PAGE_BYTES = 1 << OFFS_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_PROG
  } progState_t;

  typedef struct packed {
    logic startWin;
    logic latchAddr;
    logic loadByte;
    logic eraseSec;
    logic commitSec;
    logic busy;
  } pageCtrl_t;
endpackage

// File: rtl/pageprog_ctrl.sv
module pageprog_ctrl
  import pageprog_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  output pageCtrl_t ctl
);
  localparam int IW = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(LOAD_TIMEOUT - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 2);

  progState_t    state;
  logic [IW-1:0] idleCnt;
  logic [PW-1:0] progCnt;
  logic          wrAct, prevAct, strobeOk;
  logic          strobeStart, strobeEnd, busyNow;

  // merged write strobe: both selects low, output enable high
  assign wrAct       = !ceN && !weN && oeN;
  assign strobeStart = wrAct && !prevAct;
  assign strobeEnd   = !wrAct && prevAct;
  assign busyNow     = (state == ST_ERASE) || (state == ST_PROG);

  always_comb begin
    ctl           = '0;
    ctl.startWin  = strobeStart && (state == ST_IDLE);
    ctl.latchAddr = strobeStart && !busyNow;
    ctl.loadByte  = strobeEnd && strobeOk && (state == ST_LOAD);
    ctl.eraseSec  = (state == ST_ERASE);
    ctl.commitSec = (state == ST_PROG) && (progCnt == PROG_LAST);
    ctl.busy      = busyNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAct  <= 1'b0;
      strobeOk <= 1'b0;
      state    <= ST_IDLE;
      idleCnt  <= '0;
      progCnt  <= '0;
    end else begin
      prevAct <= wrAct;
      if (ctl.latchAddr)   strobeOk <= 1'b1;
      else if (strobeEnd)  strobeOk <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ctl.startWin) begin
            state   <= ST_LOAD;
            idleCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (wrAct || ctl.loadByte) idleCnt <= '0;
          else if (idleCnt == IDLE_LAST) state <= ST_ERASE;
          else idleCnt <= idleCnt + 1'b1;
        end
        ST_ERASE: begin
          state   <= ST_PROG;
          progCnt <= '0;
        end
        ST_PROG: begin
          if (progCnt == PROG_LAST) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  busy_from_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyNow) |-> ($past(state) == ST_LOAD) && !$past(wrAct));

  // R7
  erase_then_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE) |=> (state == ST_PROG) && (progCnt == '0));

  // R7
  prog_uninterrupted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) && (progCnt != PROG_LAST) |=> (state == ST_PROG));
endmodule

// File: rtl/pageprog_datapath.sv
module pageprog_datapath
  import pageprog_pkg::*;
#(
  parameter int SECTOR_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pageCtrl_t                     ctl,
  input  logic                          ceN,
  input  logic                          oeN,
  input  logic                          weN,
  input  logic [OFFS_W+SECTOR_BITS-1:0] addr,
  input  logic [BYTE_W-1:0]             dataIn,
  output logic [BYTE_W-1:0]             dataOut,
  output logic                          dataOe
);
  localparam int AW        = OFFS_W + SECTOR_BITS;
  localparam int MEM_BYTES = 1 << AW;

  logic [BYTE_W-1:0]      mem     [MEM_BYTES];
  logic [BYTE_W-1:0]      pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  validMask;
  logic [AW-1:0]          addrLat;
  logic [SECTOR_BITS-1:0] winSector;
  logic                   pollBit;
  logic                   sectorHit, rdEn;

  assign sectorHit = (addrLat[AW-1:OFFS_W] == winSector);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat   <= '0;
      winSector <= '0;
      validMask <= '0;
      pollBit   <= 1'b0;
    end else begin
      if (ctl.latchAddr) addrLat <= addr;
      if (ctl.startWin) begin
        winSector <= addr[AW-1:OFFS_W];
        validMask <= '0;
      end else if (ctl.loadByte && sectorHit) begin
        validMask[addrLat[OFFS_W-1:0]] <= 1'b1;
        pollBit                        <= dataIn[BYTE_W-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.loadByte && sectorHit) pageBuf[addrLat[OFFS_W-1:0]] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '1;
    end else if (ctl.eraseSec) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[{winSector, OFFS_W'(i)}] <= '1;
    end else if (ctl.commitSec) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (validMask[i]) mem[{winSector, OFFS_W'(i)}] <= pageBuf[i];
    end
  end

  assign rdEn   = !ceN && !oeN && weN;
  assign dataOe = rdEn;

  always_comb begin
    if (!rdEn)        dataOut = '0;
    else if (ctl.busy) dataOut = {~pollBit, {(BYTE_W-1){1'b0}}};
    else              dataOut = mem[addr];
  end

  // R10
  mask_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startWin |=> (validMask == '0));

  // R4
  foreign_sector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadByte && !sectorHit) |=> $stable(validMask) && $stable(pollBit));

  // R9
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |=> $stable(pollBit));

  // R8
  poll_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && dataOe) |-> (dataOut[BYTE_W-2:0] == '0));
endmodule

// File: rtl/pageprog_top.sv
module pageprog_top
  import pageprog_pkg::*;
#(
  parameter int SECTOR_BITS  = 2,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ceN,
  input  logic                          oeN,
  input  logic                          weN,
  input  logic [OFFS_W+SECTOR_BITS-1:0] addr,
  input  logic [BYTE_W-1:0]             dataIn,
  output logic [BYTE_W-1:0]             dataOut,
  output logic                          dataOe,
  output logic                          busy
);
  pageCtrl_t ctl;

  pageprog_ctrl #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .ceN (ceN),
    .oeN (oeN),
    .weN (weN),
    .ctl (ctl)
  );

  pageprog_datapath #(
    .SECTOR_BITS(SECTOR_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .ceN    (ceN),
    .oeN    (oeN),
    .weN    (weN),
    .addr   (addr),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .dataOe (dataOe)
  );

  assign busy = ctl.busy;

  // R1
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));
endmodule

// File: tb/pageprog_top_tb.sv
module pageprog_top_tb;
  localparam int SB = 2;
  localparam int TO = 40;
  localparam int PC = 200;
  localparam int AW = 8 + SB;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataOe, busy;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0]    model   [NB];
  logic [7:0]    winBuf  [256];
  bit            winValid[256];
  logic          winB7;
  logic [SB-1:0] winSec;

  pageprog_top #(.SECTOR_BITS(SB), .LOAD_TIMEOUT(TO), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .busy(busy));

  always #10 clk = ~clk;

  function automatic logic [7:0] pollExpect(input logic b7);
    return {~b7, 7'h00};
  endfunction

  function automatic logic [7:0] progExpect(input int off);
    return winValid[off] ? winBuf[off] : 8'hFF;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic openWindow(input logic [SB-1:0] s);
    winSec = s;
    for (int i = 0; i < 256; i++) winValid[i] = 0;
  endtask

  task automatic modelLoad(input logic [AW-1:0] a, input logic [7:0] d);
    if (a[AW-1:8] == winSec) begin
      winBuf[a[7:0]]   = d;
      winValid[a[7:0]] = 1;
      winB7            = d[7];
    end
  endtask

  task automatic commitModel();
    for (int i = 0; i < 256; i++) model[{winSec, 8'(i)}] = progExpect(i);
  endtask

  task automatic writeByte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 0; oeN = 1; weN = 0; dataIn = 8'($urandom);
    @(negedge clk);
    dataIn = d; weN = 1;
    @(negedge clk);
    ceN = 1; dataIn = 8'($urandom); addr = AW'($urandom);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ceN = 0; oeN = 0; weN = 1;
    #1;
    d = dataOut; oe = dataOe;
    ceN = 1; oeN = 1;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    logic oe;
    rd(a, d, oe);
    chk(req, $sformatf("read %0h", a), d, exp);
  endtask

  task automatic waitTimeout();
    for (int k = 1; k <= TO; k++) begin
      @(negedge clk);
      if (k == TO - 1) chk("R5", "busy one cycle before timeout", busy, 0);
      if (k == TO)     chk("R5", "busy at timeout", busy, 1);
    end
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < PC + 20) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic readBack(input string req);
    for (int i = 0; i < 256; i++)
      readCheck({winSec, 8'(i)}, model[{winSec, 8'(i)}], winValid[i] ? req : "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "dataOe idle", dataOe, 0);
    chk("R1", "dataOut idle", dataOut, 0);
    readCheck(10'h123, 8'hFF, "R6");

    // R2: attempt with oeN low must not load or open a window
    @(negedge clk);
    addr = {2'd1, 8'h11}; ceN = 0; oeN = 0; weN = 0; dataIn = 8'h77;
    #1 chk("R1", "dataOe while weN low", dataOe, 0);
    @(negedge clk);
    weN = 1; ceN = 1; oeN = 1;
    repeat (TO + 5) @(negedge clk);
    chk("R2", "oeN-low attempt starts nothing", busy, 0);

    // R2: chip select falls first, write later; write rises last
    openWindow(2'd1);
    @(negedge clk);
    addr = {2'd2, 8'h99}; ceN = 0; oeN = 1; weN = 1;
    @(negedge clk);
    weN = 0; addr = {2'd1, 8'h10};
    @(negedge clk);
    addr = {2'd2, 8'h44}; dataIn = 8'h00;
    @(negedge clk);
    ceN = 1; dataIn = 8'hA5;
    @(negedge clk);
    dataIn = 8'h3C; weN = 1;
    modelLoad({2'd1, 8'h10}, 8'hA5);
    writeByte({2'd1, 8'h20}, 8'h5A);
    modelLoad({2'd1, 8'h20}, 8'h5A);
    waitTimeout();
    waitIdle(n);
    chk("R7", "busy cycle count", n + 1, PC);
    commitModel();
    readCheck({2'd1, 8'h10}, 8'hA5, "R2");
    readCheck({2'd1, 8'h20}, 8'h5A, "R3");
    readCheck({2'd1, 8'h11}, 8'hFF, "R2");
    readCheck({2'd2, 8'h44}, 8'hFF, "R4");

    // R10: new window on the same sector forgets earlier bytes
    openWindow(2'd1);
    writeByte({2'd1, 8'h30}, 8'h11);
    modelLoad({2'd1, 8'h30}, 8'h11);
    waitTimeout();
    waitIdle(n);
    commitModel();
    readCheck({2'd1, 8'h10}, 8'hFF, "R10");
    readCheck({2'd1, 8'h30}, 8'h11, "R3");

    // R5: a strobe inside the timeout keeps the window open
    openWindow(2'd3);
    writeByte({2'd3, 8'h01}, 8'h81);
    modelLoad({2'd3, 8'h01}, 8'h81);
    repeat (TO - 3) @(negedge clk);
    chk("R5", "window still open", busy, 0);
    writeByte({2'd3, 8'h02}, 8'h02);
    modelLoad({2'd3, 8'h02}, 8'h02);
    waitTimeout();
    readCheck({2'd0, 8'h00}, pollExpect(winB7), "R8");
    waitIdle(n);
    commitModel();
    readCheck({2'd3, 8'h01}, 8'h81, "R3");
    readCheck({2'd3, 8'h02}, 8'h02, "R3");

    // random sessions
    for (int s = 0; s < 6; s++) begin
      logic [SB-1:0] sec;
      int loads;
      sec = SB'($urandom);
      openWindow(sec);
      loads = 5 + int'($urandom % 26);
      for (int j = 0; j < loads; j++) begin
        logic [AW-1:0] a;
        logic [7:0] dv;
        dv = 8'($urandom);
        if (j > 0 && ($urandom % 5) == 0) a = {sec + SB'(1 + $urandom % 3), 8'($urandom)};
        else a = {sec, 8'($urandom % 64)};
        writeByte(a, dv);
        modelLoad(a, dv);
      end
      waitTimeout();
      for (int j = 0; j < 3; j++)
        readCheck(AW'($urandom), pollExpect(winB7), "R8");
      // R9: strobe during busy, opposite top bit, unloaded offset
      writeByte({sec, 8'hF0}, {~winB7, 7'h2B});
      readCheck(AW'($urandom), pollExpect(winB7), "R9");
      waitIdle(n);
      commitModel();
      readCheck({sec, 8'hF0}, 8'hFF, "R9");
      readBack("R3");
      for (int j = 0; j < 8; j++) begin
        logic [AW-1:0] a;
        a = {sec + SB'(1 + $urandom % 3), 8'($urandom)};
        readCheck(a, model[a], "R4");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule